// File: doc/BRIEF.md
# Key-Protected Two-Stage Watchdog Timer

The block is a down-counting watchdog on a small 32-bit register bus with a single-cycle read and write port. Software loads a period, enables counting, and must keep writing the clear register before the count runs out. The first time the count runs out, the block raises an interrupt and starts the next period from the load value. If the count runs out again while that interrupt is still pending and the reset output is enabled, the block sends a one-cycle system reset pulse.

All writes except those to the lock register are ignored unless software has first written a fixed key to the lock register. Any other value written there locks the block again. Reads always return data. A write to the clear register does two things: it drops the pending interrupt and restarts the count from the load value. The read data is combinational and is valid in the same cycle as the read strobe.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the block is locked, load, count and control read 0, and irq and sys_rst are low.
- R2: Writing exactly 0x1ACCE551 to offset 0xC00 unlocks the block. Writing any other value to that offset locks it. A read of 0xC00 returns 1 when locked and 0 when unlocked.
- R3: While locked, writes to offsets 0x000, 0x008 and 0x00C have no effect.
- R4: An unlocked write to offset 0x000 sets the load value and also sets the live count to the written value. Offset 0x000 reads back the load value and offset 0x004 reads back the live count. The full 32-bit range up to 0xFFFFFFFF is supported.
- R5: At offset 0x008, bit 0 enables counting and the interrupt output, and bit 1 enables the reset output. Bits 31:2 always read as 0.
- R6: While bit 0 of the control register is clear, the count holds its value.
- R7: While enabled, the count drops by one each cycle. In a cycle where the count is 0, it reloads from the load value and the interrupt becomes pending. The irq output equals the pending flag ANDed with the enable bit.
- R8: An expiry that occurs while the interrupt is already pending and control bit 1 is set produces a sys_rst pulse exactly one cycle long, in the cycle after that expiry.
- R9: When control bit 1 is clear, a second expiry produces no sys_rst pulse, and the interrupt remains pending.
- R10: An unlocked write to offset 0x00C clears the pending interrupt and reloads the count from the load value. This write takes priority over an expiry in the same cycle.
- R11: Offset 0x014 reads 1 while the interrupt is pending and 0 otherwise. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational; 0 when bus_re is low |
| irq | output | 1 | Interrupt: pending flag ANDed with the enable bit |
| sys_rst | output | 1 | One-cycle system reset pulse |

## Verification
A fault in the lock flag is visible at once through a readback of the lock offset. It also shows up a cycle after a blocked write, when the load or clear register has changed and should not have. A count that is off by even one cycle moves the cycle in which irq rises, and it moves the sys_rst pulse by the same amount. The bench therefore samples both outputs on the exact cycles computed from the load value. A pending flag that is lost or set by mistake either suppresses the reset pulse or fires it one period early. Either error appears within two periods of enabling.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int          ADDR_W  = 12,
  parameter int          DATA_W  = 32,
  parameter logic [31:0] KEY     = 32'h1ACCE551
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sys_rst
);
  localparam logic [ADDR_W-1:0] OFS_LOAD = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] OFS_CNT  = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] OFS_CTL  = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] OFS_CLR  = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(12'h014);
  localparam logic [ADDR_W-1:0] OFS_LOCK = ADDR_W'(12'hC00);

  logic              locked;
  logic [DATA_W-1:0] load_q, cnt;
  logic              ctl_en, ctl_rst, pend;

  wire open_wr  = bus_we && !locked;
  wire wr_load  = open_wr && bus_addr == OFS_LOAD;
  wire wr_ctl   = open_wr && bus_addr == OFS_CTL;
  wire wr_clr   = open_wr && bus_addr == OFS_CLR;
  wire wr_lock  = bus_we && bus_addr == OFS_LOCK;
  wire expire   = ctl_en && cnt == '0 && !wr_load && !wr_clr;

  assign irq = pend && ctl_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) locked <= 1'b1;
    else if (wr_lock) locked <= (bus_wdata != DATA_W'(KEY));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl_en  <= 1'b0;
      ctl_rst <= 1'b0;
    end else if (wr_ctl) begin
      ctl_en  <= bus_wdata[0];
      ctl_rst <= bus_wdata[1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) load_q <= '0;
    else if (wr_load) load_q <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          cnt <= '0;
    else if (wr_load)    cnt <= bus_wdata;
    else if (wr_clr)     cnt <= load_q;
    else if (expire)     cnt <= load_q;
    else if (ctl_en)     cnt <= cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend    <= 1'b0;
      sys_rst <= 1'b0;
    end else begin
      sys_rst <= expire && pend && ctl_rst;
      if (wr_clr)      pend <= 1'b0;
      else if (expire) pend <= 1'b1;
    end

  always_comb begin
    bus_rdata = '0;
    if (bus_re)
      case (bus_addr)
        OFS_LOAD: bus_rdata = load_q;
        OFS_CNT:  bus_rdata = cnt;
        OFS_CTL:  bus_rdata = {{(DATA_W-2){1'b0}}, ctl_rst, ctl_en};
        OFS_STAT: bus_rdata = {{(DATA_W-1){1'b0}}, pend};
        OFS_LOCK: bus_rdata = {{(DATA_W-1){1'b0}}, locked};
        default:  bus_rdata = '0;
      endcase
  end

  // R8
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !sys_rst);
  // R8
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> pend && ctl_rst);
  // R3
  locked_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && bus_we && bus_addr == OFS_LOAD) |=> $stable(load_q));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && !wr_load && !wr_clr) |=> $stable(cnt));
  // R7
  dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && cnt != '0 && !wr_load && !wr_clr) |=> cnt == $past(cnt) - 1'b1);
  // R10
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> !pend && cnt == $past(load_q));
endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq, sys_rst;
  int          n_chk = 0, n_bad = 0, pulses = 0;

  keyed_watchdog uut (.*);

  always #10 clk = ~clk;
  always @(negedge clk) if (sys_rst) pulses++;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R1 lock", 12'hC00, 1);
    rd_chk("R1 ctl", 12'h008, 0);
    rd_chk("R1 cnt", 12'h004, 0);
    rd_chk("R1 load", 12'h000, 0);
    chk("R1 irq", irq, 0);
    chk("R1 sys_rst", sys_rst, 0);
    rd_chk("R11 unmapped", 12'h010, 0);
  endtask

  task automatic t_lock;
    wr(12'h000, 32'd7);
    rd_chk("R3 load while locked", 12'h000, 0);
    wr(12'hC00, 32'h1ACCE550);
    rd_chk("R2 near key", 12'hC00, 1);
    wr(12'hC00, 32'h1ACCE551);
    rd_chk("R2 unlocked", 12'hC00, 0);
  endtask

  task automatic t_load_ctl;
    wr(12'h000, 32'd10);
    rd_chk("R4 load", 12'h000, 10);
    rd_chk("R4 cnt preset", 12'h004, 10);
    wr(12'h008, 32'hFFFF_FFFC);
    rd_chk("R5 reserved", 12'h008, 0);
    wait_cyc(5);
    rd_chk("R6 hold", 12'h004, 10);
  endtask

  task automatic t_count_irq;
    wr(12'h008, 32'h1);
    rd_chk("R5 ctl", 12'h008, 1);
    rd_chk("R7 start", 12'h004, 10);
    wait_cyc(3);
    rd_chk("R7 dec", 12'h004, 7);
    wait_cyc(7);
    rd_chk("R7 zero", 12'h004, 0);
    chk("R7 irq before", irq, 0);
    wait_cyc(1);
    chk("R7 irq", irq, 1);
    rd_chk("R7 reload", 12'h004, 10);
    rd_chk("R11 status", 12'h014, 1);
    wait_cyc(11);
    chk("R9 no pulse", pulses, 0);
    chk("R9 still pending", irq, 1);
  endtask

  task automatic t_clear_escalate;
    wr(12'h00C, 32'h1);
    rd_chk("R10 status", 12'h014, 0);
    rd_chk("R10 reload", 12'h004, 10);
    chk("R10 irq", irq, 0);
    wr(12'h008, 32'h3);
    wr(12'h00C, 32'h1);
    wait_cyc(10);
    chk("R8 none yet", irq, 0);
    wait_cyc(1);
    chk("R8 first irq", irq, 1);
    chk("R8 no rst first", sys_rst, 0);
    wait_cyc(10);
    chk("R8 before second", sys_rst, 0);
    wait_cyc(1);
    chk("R8 pulse", sys_rst, 1);
    wait_cyc(1);
    chk("R8 one cycle", sys_rst, 0);
    chk("R8 pulse count", pulses, 1);
    rd_chk("R8 keeps counting", 12'h004, 9);
  endtask

  task automatic t_relock_max;
    logic [31:0] c0;
    wr(12'hC00, 32'h1234_5678);
    rd_chk("R2 relocked", 12'hC00, 1);
    wr(12'h00C, 32'h1);
    rd_chk("R3 clr ignored", 12'h014, 1);
    wr(12'h008, 32'h0);
    rd_chk("R3 ctl ignored", 12'h008, 3);
    rd(12'h004, c0);
    wait_cyc(2);
    rd_chk("R3 still counting", 12'h004, c0 - 2);
    wr(12'hC00, 32'h1ACCE551);
    wr(12'h008, 32'h0);
    wr(12'h000, 32'hFFFF_FFFF);
    rd_chk("R4 max", 12'h004, 32'hFFFF_FFFF);
    chk("R7 irq gated", irq, 0);
    wr(12'h008, 32'h1);
    wait_cyc(2);
    rd_chk("R4 max dec", 12'h004, 32'hFFFF_FFFD);
  endtask

  initial begin
    fork
      begin
        #45 rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_lock();
        t_load_ctl();
        t_count_irq();
        t_clear_escalate();
        t_relock_max();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule